// File: doc/BRIEF.md
# Boot Alias Address Decoder

This block sits on the address path of one bus master and turns each address into a single region select: the on-chip ROM, the on-chip SRAM, or one of several external chip-select windows. It also gives back the offset of the address inside the selected region. Addresses that fall in no region are reported as decode errors.

The lowest 1 MB of the address space is an alias window. It never owns memory of its own. Instead it points at one of three real targets:
- the SRAM, when software has set the remap control bit;
- otherwise the ROM, when the boot strap was high while reset was active;
- otherwise external chip select 0.

The strap is captured only while reset is applied. The remap bit is a one-bit register that software sets after boot through a small write port. Its current value is always visible on an output. Each real region also stays reachable at its own fixed base, whatever the alias currently points at.

The decode result is registered. It appears on the outputs on the clock edge that follows the cycle in which the address was presented with its valid strobe.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `remap_o` is 0, `sel_o` is all zero, `offs_o` is zero and `dec_err_o` is 0.
- R2: The strap level present on the last clock edge of reset is kept until the next reset. Changes on `strap_i` while reset is low have no effect on the decode.
- R3: With the remap bit at 0 and the captured strap at 1, an address below 0x0010_0000 selects the ROM (`sel_o` bit 0). The offset is the address itself.
- R4: With the remap bit at 0 and the captured strap at 0, an address below 0x0010_0000 selects external chip select 0 (`sel_o` bit 2). The offset is the address itself.
- R5: With the remap bit at 1, an address below 0x0010_0000 selects the SRAM (`sel_o` bit 1), whatever the strap. The offset is the address itself.
- R6: A write cycle (`reg_wr_i` high) loads `reg_wdata_i` into the remap bit, and the new value is visible on `remap_o` one cycle later. An access presented in the same cycle as the write is decoded with the old value. Later accesses use the new value.
- R7: The fixed regions decode independently of the alias, each with offset = address − base:
  - `sel_o` bit 0 is the ROM, 64 KB at 0x0010_0000.
  - `sel_o` bit 1 is the SRAM, 128 KB at 0x0020_0000.
  - `sel_o` bit 2+i is external chip select i, with a 256 MB window at 0x1000_0000 + i·0x1000_0000, for i in 0..3.
- R8: An address that falls in no region gives an all-zero `sel_o`, a zero offset, and a `dec_err_o` pulse one cycle long.
- R9: Outputs are registered. The result for an address valid in cycle t appears after the clock edge that ends cycle t. A cycle with `addr_vld_i` low yields all-zero `sel_o`, zero `offs_o` and `dec_err_o` 0 on the next cycle. A valid mapped address gives exactly one bit set in `sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| strap_i | input | 1 | Boot-mode strap: 1 = boot from ROM, 0 = boot from chip select 0 |
| reg_wr_i | input | 1 | Remap register write strobe |
| reg_wdata_i | input | 1 | Value written to the remap bit |
| remap_o | output | 1 | Current remap bit (read-back) |
| addr_i | input | 32 | Bus address |
| addr_vld_i | input | 1 | Address valid strobe |
| sel_o | output | 6 | One-hot region select: bit0 ROM, bit1 SRAM, bit 2+i chip select i |
| offs_o | output | 32 | Offset inside the selected region |
| dec_err_o | output | 1 | One-cycle pulse for an unmapped valid address |

## Verification
Two functions can fall in the same cycle:
- a remap register write;
- an access to the alias window.

The bench provokes this by raising the write strobe and a valid alias address on the same falling edge. It expects the result registered at the next edge to show the pre-write target (ROM or chip select 0, by strap), while `remap_o` already shows the new bit. It then repeats the alias access alone and expects the SRAM. Every region boundary, plus a sweep over all sixteen 256 MB slots, is checked for both remap values and both strap levels, against a bench model computed from the address arithmetic.

// File: rtl/brd_pkg.sv
package brd_pkg;

  // Fixed positions inside the region select vector
  localparam int REG_ROM  = 0;
  localparam int REG_SRAM = 1;
  localparam int REG_CS0  = 2;

  typedef enum logic [1:0] {
    TGT_ROM  = 2'd0,
    TGT_SRAM = 2'd1,
    TGT_CS0  = 2'd2
  } alias_tgt_e;

endpackage

// File: rtl/brd_window.sv
module brd_window #(
  parameter int                 ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter int                 AW     = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offs_o
);

  // Aligned window: compare only the bits above the window size
  assign hit_o  = (addr_i[ADDR_W-1:AW] == BASE[ADDR_W-1:AW]);
  assign offs_o = addr_i - BASE;

endmodule

// File: rtl/brd_strap_latch.sv
module brd_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  output logic strap_o
);

  // Follows the pin during reset, freezes on the last reset edge
  always_ff @(posedge clk) begin
    if (rst) strap_o <= strap_i;
  end

endmodule

// File: rtl/brd_remap_reg.sv
module brd_remap_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic wdata_i,
  output logic remap_o
);

  always_ff @(posedge clk) begin
    if (rst)       remap_o <= 1'b0;
    else if (wr_i) remap_o <= wdata_i;
  end

endmodule

// File: rtl/brd_decode.sv
module brd_decode
  import brd_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 ALIAS_AW  = 20,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0010_0000,
  parameter int                 ROM_AW    = 16,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h0020_0000,
  parameter int                 SRAM_AW   = 17,
  parameter logic [ADDR_W-1:0] CS_BASE   = 32'h1000_0000,
  parameter int                 CS_AW     = 28,
  parameter int                 NUM_CS    = 4,
  localparam int                NREG      = REG_CS0 + NUM_CS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              remap_i,
  input  logic              strap_i,
  output logic [NREG-1:0]   sel_o,
  output logic [ADDR_W-1:0] offs_o,
  output logic              unmapped_o
);

  function automatic logic [ADDR_W-1:0] base_of(int r);
    if (r == REG_ROM)  return ROM_BASE;
    if (r == REG_SRAM) return SRAM_BASE;
    return CS_BASE + (ADDR_W'(r - REG_CS0) << CS_AW);
  endfunction

  function automatic int aw_of(int r);
    if (r == REG_ROM)  return ROM_AW;
    if (r == REG_SRAM) return SRAM_AW;
    return CS_AW;
  endfunction

  logic [NREG-1:0]   win_hit;
  logic [ADDR_W-1:0] win_offs [NREG];
  logic              alias_hit;
  logic [ADDR_W-1:0] alias_offs;
  alias_tgt_e        tgt;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    brd_window #(
      .ADDR_W (ADDR_W),
      .BASE   (base_of(g)),
      .AW     (aw_of(g))
    ) u_win (
      .addr_i (addr_i),
      .hit_o  (win_hit[g]),
      .offs_o (win_offs[g])
    );
  end

  brd_window #(
    .ADDR_W (ADDR_W),
    .BASE   ('0),
    .AW     (ALIAS_AW)
  ) u_alias (
    .addr_i (addr_i),
    .hit_o  (alias_hit),
    .offs_o (alias_offs)
  );

  always_comb begin
    if (remap_i)      tgt = TGT_SRAM;
    else if (strap_i) tgt = TGT_ROM;
    else              tgt = TGT_CS0;
  end

  always_comb begin
    sel_o      = '0;
    offs_o     = '0;
    unmapped_o = 1'b0;
    if (alias_hit) begin
      case (tgt)
        TGT_ROM:  sel_o[REG_ROM]  = 1'b1;
        TGT_SRAM: sel_o[REG_SRAM] = 1'b1;
        TGT_CS0:  sel_o[REG_CS0]  = 1'b1;
        default:  sel_o           = '0;
      endcase
      offs_o = alias_offs;
    end else if (|win_hit) begin
      sel_o = win_hit;
      for (int r = 0; r < NREG; r++) begin
        if (win_hit[r]) offs_o = win_offs[r];
      end
    end else begin
      unmapped_o = 1'b1;
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 ALIAS_AW  = 20,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0010_0000,
  parameter int                 ROM_AW    = 16,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h0020_0000,
  parameter int                 SRAM_AW   = 17,
  parameter logic [ADDR_W-1:0] CS_BASE   = 32'h1000_0000,
  parameter int                 CS_AW     = 28,
  parameter int                 NUM_CS    = 4,
  localparam int                NREG      = REG_CS0 + NUM_CS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              reg_wr_i,
  input  logic              reg_wdata_i,
  output logic              remap_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  output logic [NREG-1:0]   sel_o,
  output logic [ADDR_W-1:0] offs_o,
  output logic              dec_err_o
);

  logic              strap_q;
  logic [NREG-1:0]   dec_sel;
  logic [ADDR_W-1:0] dec_offs;
  logic              dec_unmapped;

  brd_strap_latch u_strap (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap_i),
    .strap_o (strap_q)
  );

  brd_remap_reg u_remap (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .remap_o (remap_o)
  );

  brd_decode #(
    .ADDR_W    (ADDR_W),
    .ALIAS_AW  (ALIAS_AW),
    .ROM_BASE  (ROM_BASE),
    .ROM_AW    (ROM_AW),
    .SRAM_BASE (SRAM_BASE),
    .SRAM_AW   (SRAM_AW),
    .CS_BASE   (CS_BASE),
    .CS_AW     (CS_AW),
    .NUM_CS    (NUM_CS)
  ) u_dec (
    .addr_i     (addr_i),
    .remap_i    (remap_o),
    .strap_i    (strap_q),
    .sel_o      (dec_sel),
    .offs_o     (dec_offs),
    .unmapped_o (dec_unmapped)
  );

  always_ff @(posedge clk) begin
    if (rst || !addr_vld_i) begin
      sel_o     <= '0;
      offs_o    <= '0;
      dec_err_o <= 1'b0;
    end else begin
      sel_o     <= dec_sel;
      offs_o    <= dec_offs;
      dec_err_o <= dec_unmapped;
    end
  end

endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int NREG = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            strap_q,
  input logic            reg_wr_i,
  input logic            reg_wdata_i,
  input logic            remap_o,
  input logic            addr_vld_i,
  input logic [NREG-1:0] sel_o,
  input logic            dec_err_o
);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(strap_q));

  // R6
  remap_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_i |=> (remap_o == $past(reg_wdata_i)));

  // R6
  remap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_i |=> $stable(remap_o));

  // R8
  err_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    dec_err_o |-> (sel_o == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_vld_i |=> ((sel_o == '0) && !dec_err_o));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  // R8
  err_or_sel_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i |=> ($countones({sel_o, dec_err_o}) == 1));

endmodule

bind boot_remap_decoder brd_checker #(
  .NREG (NREG)
) u_brd_chk (
  .clk         (clk),
  .rst         (rst),
  .strap_q     (strap_q),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .remap_o     (remap_o),
  .addr_vld_i  (addr_vld_i),
  .sel_o       (sel_o),
  .dec_err_o   (dec_err_o)
);

// File: tb/tb_boot_remap_decoder.sv
`timescale 1ns/1ps
module tb_boot_remap_decoder;

  localparam int NREG = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_i = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic        reg_wdata_i = 1'b0;
  logic        remap_o;
  logic [31:0] addr_i = '0;
  logic        addr_vld_i = 1'b0;
  logic [5:0]  sel_o;
  logic [31:0] offs_o;
  logic        dec_err_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  boot_remap_decoder dut (
    .clk         (clk),
    .rst         (rst),
    .strap_i     (strap_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .remap_o     (remap_o),
    .addr_i      (addr_i),
    .addr_vld_i  (addr_vld_i),
    .sel_o       (sel_o),
    .offs_o      (offs_o),
    .dec_err_o   (dec_err_o)
  );

  logic [31:0] rbase [6] = '{32'h0010_0000, 32'h0020_0000, 32'h1000_0000,
                             32'h2000_0000, 32'h3000_0000, 32'h4000_0000};
  logic [31:0] rsize [6] = '{32'h0001_0000, 32'h0002_0000, 32'h1000_0000,
                             32'h1000_0000, 32'h1000_0000, 32'h1000_0000};

  // Bench model of the address map
  task automatic model(input logic [31:0] a, input logic rm, input logic st,
                       output logic [5:0] es, output logic [31:0] eo,
                       output logic ee);
    es = '0; eo = '0; ee = 1'b0;
    if (a < 32'h0010_0000) begin
      if (rm)      es[1] = 1'b1;
      else if (st) es[0] = 1'b1;
      else         es[2] = 1'b1;
      eo = a;
    end else begin
      for (int r = 0; r < 6; r++) begin
        if (a >= rbase[r] && {1'b0, a} < {1'b0, rbase[r]} + {1'b0, rsize[r]}) begin
          es[r] = 1'b1;
          eo = a - rbase[r];
        end
      end
      if (es == '0) ee = 1'b1;
    end
  endtask

  task automatic check(input string req, input logic [5:0] es,
                       input logic [31:0] eo, input logic ee,
                       input logic [31:0] a);
    total++;
    if (sel_o !== es || offs_o !== eo || dec_err_o !== ee) begin
      bad++;
      $display("FAIL %s addr=%h actual sel=%b offs=%h err=%b expected sel=%b offs=%h err=%b",
               req, a, sel_o, offs_o, dec_err_o, es, eo, ee);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] a, input logic rm, input logic st);
    if (a < 32'h0010_0000) return rm ? "R5" : (st ? "R3" : "R4");
    return "R7/R8";
  endfunction

  // One access: drive at negedge, registered result seen at next negedge
  task automatic access(input logic [31:0] a, input logic rm, input logic st);
    logic [5:0] es; logic [31:0] eo; logic ee;
    model(a, rm, st, es, eo, ee);
    addr_i = a; addr_vld_i = 1'b1;
    @(negedge clk);
    addr_vld_i = 1'b0;
    check(tag_of(a, rm, st), es, eo, ee, a);
  endtask

  task automatic do_reset(input logic st);
    rst = 1'b1; strap_i = ~st;
    repeat (2) @(negedge clk);
    strap_i = st;
    @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after release
    check_bit("R1 remap", remap_o, 1'b0);
    check("R1", '0, '0, 1'b0, 32'h0);
  endtask

  task automatic set_remap(input logic v);
    reg_wr_i = 1'b1; reg_wdata_i = v;
    @(negedge clk);
    reg_wr_i = 1'b0;
    check_bit("R6 readback", remap_o, v);
  endtask

  task automatic sweep(input logic rm, input logic st);
    for (int r = 0; r < 6; r++) begin
      access(rbase[r] - 32'd1, rm, st);
      access(rbase[r], rm, st);
      access(rbase[r] + 32'd1, rm, st);
      access(rbase[r] + (rsize[r] >> 1), rm, st);
      access(rbase[r] + rsize[r] - 32'd1, rm, st);
      access(rbase[r] + rsize[r], rm, st);
    end
    for (int k = 0; k < 16; k++) begin
      access({k[3:0], 28'h00A_BC35}, rm, st);
    end
    access(32'h0000_0000, rm, st);
    access(32'h000F_FFFF, rm, st);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 during reset
    repeat (2) @(negedge clk);
    check_bit("R1 remap in reset", remap_o, 1'b0);
    check("R1 in reset", '0, '0, 1'b0, 32'h0);

    for (int s = 1; s >= 0; s--) begin
      do_reset(s[0]);
      // R2: pin toggles after reset must be ignored
      strap_i = ~s[0];
      access(32'h0000_1234, 1'b0, s[0]);
      strap_i = s[0];
      sweep(1'b0, s[0]);
      // R9: idle cycle yields zero outputs
      @(negedge clk);
      check("R9 idle", '0, '0, 1'b0, 32'h0);

      // R6: write and alias access in the same cycle use the old bit
      reg_wr_i = 1'b1; reg_wdata_i = 1'b1;
      addr_i = 32'h0000_0040; addr_vld_i = 1'b1;
      @(negedge clk);
      reg_wr_i = 1'b0; addr_vld_i = 1'b0;
      check("R6 same-cycle", s[0] ? 6'b000001 : 6'b000100, 32'h40, 1'b0, 32'h40);
      check_bit("R6 readback", remap_o, 1'b1);
      access(32'h0000_0040, 1'b1, s[0]);

      strap_i = ~s[0];  // R2/R5: strap ignored once remapped
      sweep(1'b1, s[0]);
      strap_i = s[0];
      set_remap(1'b0);
      access(32'h0008_0000, 1'b0, s[0]);
      set_remap(1'b1);
      access(32'h0008_0000, 1'b1, s[0]);
    end

    // R8: error is a single-cycle pulse
    access(32'h0800_0000, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 pulse end", '0, '0, 1'b0, 32'h0800_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule